// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This block is a register-mapped accelerator that keeps a running CRC or 16-bit ones'-complement checksum. Software picks the algorithm and the input handling through a control register. It then writes data words one at a time. Each data write folds one word, or one byte, into the running context in a single clock cycle. A read of the result register returns the context after the optional output bit reversal and inversion. A read of the seed register returns the raw context, so a stream can be suspended and later resumed by writing that value back.

The bus is a plain valid/write/address/data interface. A write takes effect at the clock edge on which it is presented. A read is answered one clock later: `bus_rvalid` goes high for one cycle and `bus_rdata` holds the value from that edge until the next read. Four CRC generators are supported: 0x8005 and 0x1021 (16-bit), and 0x04C11DB7 and 0x1EDC6F41 (32-bit). The checksum folds 16-bit halves with end-around carry.

The control path has no sequencing: every access completes in the cycle it is presented. For that reason the block is built as a register file around a combinational datapath, not as a state machine.

Top module: `crc_accel`

## Requirements
- R1: Registers decode on `bus_addr`: control 0x400, seed/context 0x410, data 0x414, result 0x418. A read returns its value one cycle after the request, with `bus_rvalid` high for exactly that cycle. Control reads back only its defined bits (mask 0x000073BF). The data register and unmapped addresses read as 0.
- R2: After reset, control, context and the read data are all zero.
- R3: Control bits [3:0] select the operation: 0 = CRC poly 0x8005, 1 = CRC poly 0x1021, 2 = CRC poly 0x04C11DB7, 3 = CRC poly 0x1EDC6F41, 8 = checksum. The CRC shifts data MSB first, without reflection. Codes 0 and 1 use the low 16 context bits only, and their result bits [31:16] read as 0.
- R4: Writing control loads the context according to bits [14:13]: 00 keeps the current context (the seed), 10 clears it, 11 sets it to all ones.
- R5: Writing the seed register replaces the context with the written word. Reading the seed register returns the context without any post-processing.
- R6: Control bits [5:4] reorder the data word's bytes B3..B0 (B3 = bits 31:24) before processing. 00 gives B3,B2,B1,B0; 01 gives B2,B3,B0,B1; 10 gives B1,B0,B3,B2; 11 gives B0,B1,B2,B3 (listed MSB to LSB). After reordering, the word's most significant byte is processed first.
- R7: Control bit 7 reverses the bit order inside each byte after reordering.
- R8: Control bit 12 set: only the low byte of the reordered word is processed and the other bytes have no effect. Bit 12 clear: all 32 bits are processed.
- R9: Control bit 8 bit-reverses the result over the operation width (16 or 32 bits). Control bit 9 inverts the result over that width.
- R10: In checksum mode the two 16-bit halves of the word (in byte mode, the zero-extended low byte) are added into a 16-bit ones'-complement sum with end-around carry. The checksum width is 16 bits.
- R11: A data write with an undefined operation code leaves the context unchanged. No access other than a write changes the context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
Writes update the context at the edge that samples them, so a read issued in the next cycle already sees the new state. Its data is due one edge after that request. The bench drives every access on the falling edge and holds it for one cycle. It samples `bus_rdata` and `bus_rvalid` on the falling edge that follows the responding rising edge, which is halfway through the cycle in which the result is due. Expected CRC values are the standard published check values for the nine-byte ASCII string "123456789", reached through byte streams and through word streams under every byte ordering.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int HALF_W = WORD_W / 2;

    localparam logic [11:0] OFS_CTRL   = 12'h400;
    localparam logic [11:0] OFS_SEED   = 12'h410;
    localparam logic [11:0] OFS_DATA   = 12'h414;
    localparam logic [11:0] OFS_RESULT = 12'h418;

    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_73BF;

    typedef enum logic [3:0] {
        OP_P16A  = 4'd0,
        OP_P16B  = 4'd1,
        OP_P32A  = 4'd2,
        OP_P32B  = 4'd3,
        OP_CKSUM = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        INIT_KEEP  = 2'b00,
        INIT_RSVD  = 2'b01,
        INIT_ZERO  = 2'b10,
        INIT_ONES  = 2'b11
    } init_e;

    typedef struct packed {
        logic [1:0] init;
        logic       byte_mode;
        logic       inv_out;
        logic       rev_out;
        logic       rev_in;
        logic [1:0] order;
        logic [3:0] op;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] r);
        ctrl_t c;
        c.init      = r[14:13];
        c.byte_mode = r[12];
        c.inv_out   = r[9];
        c.rev_out   = r[8];
        c.rev_in    = r[7];
        c.order     = r[5:4];
        c.op        = r[3:0];
        return c;
    endfunction

    function automatic logic op_is_wide(input logic [3:0] op);
        return (op == OP_P32A) || (op == OP_P32B);
    endfunction

    function automatic logic op_is_crc(input logic [3:0] op);
        return (op == OP_P16A) || (op == OP_P16B) || op_is_wide(op);
    endfunction

    function automatic logic [WORD_W-1:0] op_poly(input logic [3:0] op);
        logic [WORD_W-1:0] p;
        unique case (op)
            OP_P16A: p = 32'h0000_8005;
            OP_P16B: p = 32'h0000_1021;
            OP_P32A: p = 32'h04C1_1DB7;
            OP_P32B: p = 32'h1EDC_6F41;
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/crc_input_shaper.sv
module crc_input_shaper
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    input  logic [1:0]        order,
    input  logic              rev_in,
    output logic [WORD_W-1:0] dout
);

    logic [WORD_W-1:0] swapped;

    always_comb begin
        unique case (order)
            2'b00: swapped = din;
            2'b01: swapped = {din[23:16], din[31:24], din[7:0], din[15:8]};
            2'b10: swapped = {din[15:0], din[31:16]};
            2'b11: swapped = {din[7:0], din[15:8], din[23:16], din[31:24]};
            default: swapped = din;
        endcase
    end

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            assign dout[lane*BYTE_W + b] = rev_in ? swapped[lane*BYTE_W + (BYTE_W-1-b)]
                                                  : swapped[lane*BYTE_W + b];
        end
    end

endmodule

// File: rtl/crc_update.sv
module crc_update
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] ctx,
    input  logic [WORD_W-1:0] data,
    input  logic [3:0]        op,
    input  logic              byte_mode,
    output logic [WORD_W-1:0] ctx_next
);

    function automatic logic [WORD_W-1:0] crc_fold(
        input logic [WORD_W-1:0] c_in,
        input logic [WORD_W-1:0] d,
        input logic              wide,
        input logic [WORD_W-1:0] poly,
        input logic              one_byte
    );
        logic [WORD_W-1:0] c;
        logic              fb;
        c = c_in;
        for (int i = WORD_W-1; i >= 0; i--) begin
            if (!one_byte || i < BYTE_W) begin
                fb = (wide ? c[WORD_W-1] : c[HALF_W-1]) ^ d[i];
                c  = {c[WORD_W-2:0], 1'b0};
                if (fb) c = c ^ poly;
            end
        end
        if (!wide) c[WORD_W-1:HALF_W] = '0;
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] sum_fold(
        input logic [WORD_W-1:0] c_in,
        input logic [WORD_W-1:0] d,
        input logic              one_byte
    );
        logic [HALF_W+1:0] s;
        logic [HALF_W-1:0] hi, lo;
        hi = one_byte ? '0 : d[WORD_W-1:HALF_W];
        lo = one_byte ? {8'h00, d[BYTE_W-1:0]} : d[HALF_W-1:0];
        s  = {2'b00, c_in[HALF_W-1:0]} + {2'b00, hi} + {2'b00, lo};
        s  = {2'b00, s[HALF_W-1:0]} + {{HALF_W{1'b0}}, s[HALF_W+1:HALF_W]};
        s  = {2'b00, s[HALF_W-1:0]} + {{HALF_W{1'b0}}, s[HALF_W+1:HALF_W]};
        return {{HALF_W{1'b0}}, s[HALF_W-1:0]};
    endfunction

    always_comb begin
        if (op_is_crc(op))
            ctx_next = crc_fold(ctx, data, op_is_wide(op), op_poly(op), byte_mode);
        else if (op == OP_CKSUM)
            ctx_next = sum_fold(ctx, data, byte_mode);
        else
            ctx_next = ctx;
    end

    always_comb begin
        if (op == OP_CKSUM)
            p_sum_upper_zero_r10: assert (ctx_next[WORD_W-1:HALF_W] == '0);
    end

endmodule

// File: rtl/crc_post.sv
module crc_post
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] ctx,
    input  logic              wide,
    input  logic              rev_out,
    input  logic              inv_out,
    output logic [WORD_W-1:0] result
);

    logic [WORD_W-1:0] base, rev32, rev16, stage1;

    assign base = wide ? ctx : {{HALF_W{1'b0}}, ctx[HALF_W-1:0]};

    for (genvar i = 0; i < WORD_W; i++) begin : g_rev32
        assign rev32[i] = base[WORD_W-1-i];
    end
    for (genvar i = 0; i < HALF_W; i++) begin : g_rev16
        assign rev16[i] = base[HALF_W-1-i];
    end
    assign rev16[WORD_W-1:HALF_W] = '0;

    always_comb begin
        if (!rev_out)  stage1 = base;
        else if (wide) stage1 = rev32;
        else           stage1 = rev16;

        if (!inv_out)  result = stage1;
        else if (wide) result = ~stage1;
        else           result = {{HALF_W{1'b0}}, ~stage1[HALF_W-1:0]};
    end

endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_SEED   = ADDR_W'(OFS_SEED);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_RESULT = ADDR_W'(OFS_RESULT);

    logic [WORD_W-1:0] ctrl_q, ctx_q;
    ctrl_t             cfg;
    logic [WORD_W-1:0] shaped, ctx_upd, result;
    logic              wr_ctrl, wr_seed, wr_data, rd_req;
    ctrl_t             new_cfg;

    assign cfg     = unpack_ctrl(ctrl_q);
    assign new_cfg = unpack_ctrl(bus_wdata);
    assign rd_req  = bus_valid && !bus_write;
    assign wr_ctrl = bus_valid && bus_write && (bus_addr == A_CTRL);
    assign wr_seed = bus_valid && bus_write && (bus_addr == A_SEED);
    assign wr_data = bus_valid && bus_write && (bus_addr == A_DATA);

    crc_input_shaper u_shaper (
        .din    (bus_wdata),
        .order  (cfg.order),
        .rev_in (cfg.rev_in),
        .dout   (shaped)
    );

    crc_update u_update (
        .ctx       (ctx_q),
        .data      (shaped),
        .op        (cfg.op),
        .byte_mode (cfg.byte_mode),
        .ctx_next  (ctx_upd)
    );

    crc_post u_post (
        .ctx     (ctx_q),
        .wide    (op_is_wide(cfg.op)),
        .rev_out (cfg.rev_out),
        .inv_out (cfg.inv_out),
        .result  (result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ctx_q  <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
            unique case (init_e'(new_cfg.init))
                INIT_ZERO: ctx_q <= '0;
                INIT_ONES: ctx_q <= '1;
                default:   ctx_q <= ctx_q;
            endcase
        end else if (wr_seed) begin
            ctx_q <= bus_wdata;
        end else if (wr_data) begin
            ctx_q <= ctx_upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_req;
            if (rd_req) begin
                if (bus_addr == A_CTRL)        bus_rdata <= ctrl_q;
                else if (bus_addr == A_SEED)   bus_rdata <= ctx_q;
                else if (bus_addr == A_RESULT) bus_rdata <= result;
                else                           bus_rdata <= '0;
            end
        end
    end

    p_rvalid_follows_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    p_rvalid_only_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);
    p_narrow_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !op_is_wide(cfg.op) |-> (result[31:16] == '0));
    p_init_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[14:13] == 2'b10) |=> (ctx_q == '0));
    p_init_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[14:13] == 2'b11) |=> (ctx_q == '1));
    p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seed |=> (ctx_q == $past(bus_wdata)));
    p_ctx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(ctx_q));
    p_bad_op_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !op_is_crc(cfg.op) && cfg.op != OP_CKSUM) |=> $stable(ctx_q));

endmodule

// File: tb/crc_accel_bench.sv
module crc_accel_bench;

    localparam logic [11:0] A_CTRL = 12'h400, A_SEED = 12'h410,
                            A_DATA = 12'h414, A_RES  = 12'h418;

    // {control word, expected result} for the string "123456789"
    localparam int NVEC = 10;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_6002, 32'h0376_E6E7},   // R3 R6 32-bit poly A, order 00
        {32'h0000_6012, 32'h0376_E6E7},   // R6 order 01
        {32'h0000_6022, 32'h0376_E6E7},   // R6 order 10
        {32'h0000_6032, 32'h0376_E6E7},   // R6 order 11
        {32'h0000_6382, 32'hCBF4_3926},   // R7 R9 reflected 32-bit
        {32'h0000_7383, 32'hE306_9283},   // R8 R3 poly B byte stream
        {32'h0000_7001, 32'h0000_29B1},   // R3 R4 16-bit ones init
        {32'h0000_4000, 32'h0000_FEE8},   // R3 16-bit poly A zero init
        {32'h0000_5180, 32'h0000_BB3D},   // R7 R8 R9 reflected 16-bit bytes
        {32'h0000_4181, 32'h0000_2189}    // R7 R9 reflected 16-bit words
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    crc_accel u_crc_accel (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    function automatic logic [31:0] place(input logic [31:0] w, input logic [1:0] o);
        case (o)
            2'b01:   return {w[23:16], w[31:24], w[7:0], w[15:8]};
            2'b10:   return {w[15:0], w[31:16]};
            2'b11:   return {w[7:0], w[15:8], w[23:16], w[31:24]};
            default: return w;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, saved, c;
        logic        v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(A_CTRL, d, v); check("R2 ctrl", d, 32'h0);
        check("R1 rvalid", {31'b0, v}, 32'h1);
        rd(A_SEED, d, v); check("R2 context", d, 32'h0);
        rd(A_RES, d, v);  check("R2 result", d, 32'h0);
        @(negedge clk);
        check("R1 rvalid drops", {31'b0, bus_rvalid}, 32'h0);

        // Table of standard check values
        for (int k = 0; k < NVEC; k++) begin
            c = VEC[k][63:32];
            wr(A_CTRL, c);
            if (c[12]) begin
                for (int i = 0; i < 9; i++)
                    wr(A_DATA, place({24'hA5A5A5, 8'h31 + 8'(i)}, c[5:4]));
            end else begin
                wr(A_DATA, place(32'h3132_3334, c[5:4]));
                wr(A_DATA, place(32'h3536_3738, c[5:4]));
                wr(A_CTRL, (c & ~32'h6000) | 32'h1000);   // R4 keep context
                wr(A_DATA, place(32'h5A5A_5A39, c[5:4]));
            end
            rd(A_RES, d, v);
            check($sformatf("R3/R6/R7/R8/R9 vector %0d", k), d, VEC[k][31:0]);
        end

        // R1 control readback mask, data register reads zero
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d, v); check("R1 ctrl mask", d, 32'h0000_73BF);
        rd(A_DATA, d, v); check("R1 data reads 0", d, 32'h0);

        // R4 keep-seed and clear
        wr(A_SEED, 32'h1234_5678);
        wr(A_CTRL, 32'h0000_0002);
        rd(A_SEED, d, v); check("R4 init keep", d, 32'h1234_5678);
        wr(A_CTRL, 32'h0000_4002);
        rd(A_SEED, d, v); check("R4 init zero", d, 32'h0);

        // R3 R4 16-bit op with all-ones context, upper result zero
        wr(A_CTRL, 32'h0000_6001);
        rd(A_SEED, d, v); check("R4 init ones raw", d, 32'hFFFF_FFFF);
        rd(A_RES, d, v);  check("R3 16-bit result width", d, 32'h0000_FFFF);

        // R5 save and restore the context mid-stream
        wr(A_CTRL, 32'h0000_6002);
        wr(A_DATA, 32'h3132_3334);
        rd(A_SEED, saved, v);
        wr(A_CTRL, 32'h0000_6002);
        wr(A_SEED, saved);
        wr(A_DATA, 32'h3536_3738);
        wr(A_CTRL, 32'h0000_1002);
        wr(A_DATA, 32'h0000_0039);
        rd(A_RES, d, v); check("R5 context restore", d, 32'h0376_E6E7);

        // R10 checksum
        wr(A_CTRL, 32'h0000_4008);
        wr(A_DATA, 32'h0001_F203);
        wr(A_DATA, 32'hF4F5_F6F7);
        rd(A_RES, d, v); check("R10 checksum sum", d, 32'h0000_DDF2);
        wr(A_CTRL, 32'h0000_0208);
        rd(A_RES, d, v); check("R10 R9 checksum inverted", d, 32'h0000_220D);

        // R11 undefined operation code
        wr(A_CTRL, 32'h0000_4005);
        wr(A_DATA, 32'h1234_5678);
        rd(A_SEED, d, v); check("R11 undefined op holds", d, 32'h0);
        wr(A_SEED, 32'hCAFE_F00D);
        wr(A_DATA, 32'h89AB_CDEF);
        rd(A_SEED, d, v); check("R11 undefined op holds seed", d, 32'hCAFE_F00D);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule